// File: doc/BRIEF.md
# Serial EEPROM Write Guard and Status Register

This block keeps the status byte of a byte-wide serial EEPROM and decides, in the same clock cycle as the request, whether a requested array write or status write may start. The serial front end hands it decoded instruction events: enable-latch set and clear, array-write start with a target address, status-write start with the received data byte, and a strobe when the self-timed programming cycle has finished. The block also samples the active-low write-protect pin.

The block drives three things. The first is the status byte, which the front end shifts out on a status read; it stays readable while a cycle runs. The second is a write-permit flag that the front end uses to launch or drop the programming cycle. The third is the protected address range, given as an enable flag and a lowest protected address. Block-protect settings are applied by address page, and a new setting takes effect only when the status write that carries it completes.

Top module: `eeprom_guard`

## Requirements
- R1: The status byte holds write-in-progress in bit 0, the write-enable latch in bit 1 and the two block-protect bits in bits 3:2. Bits 7:4 always read 0. After reset the byte reads 0x00.
- R2: A write-enable event sets bit 1 at the next clock edge. A write-disable event clears it at the next clock edge.
- R3: While the protect pin is low, bit 1 is cleared at the next clock edge, and a write-enable event leaves it at 0.
- R4: An array-write request is permitted in the same cycle only when the latch is set, no cycle is running, the protect pin is high and the page of the target address is outside the protected range.
- R5: A status-write request is permitted in the same cycle only when the latch is set, the protect pin is high and no cycle is running. The new block-protect value is taken from data bits 3:2.
- R6: A permitted request sets bit 0 at the next edge. Bit 0 stays 1 until a cycle-done strobe, which clears both bit 0 and bit 1 at the next edge.
- R7: Block-protect code 00 protects nothing, 01 protects the upper quarter (from 0x180 with 9 address bits), 10 the upper half (from 0x100) and 11 the whole array. These are shown on prot_en and prot_base.
- R8: During a status-write cycle the old block-protect value stays in force in both the status byte and the range outputs. The new value appears only after the cycle-done strobe.
- R9: The protect pin going low during a running cycle does not clear bit 0. The cycle still ends on the cycle-done strobe.
- R10: A refused request leaves the status byte unchanged and starts no cycle.
- R11: A cycle-done strobe while no cycle is running has no effect on the status byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wren_evt | input | 1 | Decoded write-enable instruction pulse |
| wrdi_evt | input | 1 | Decoded write-disable instruction pulse |
| arr_wr_req | input | 1 | Request to start an array programming cycle |
| sts_wr_req | input | 1 | Request to start a status programming cycle |
| tgt_addr | input | AW | Target address of the array write |
| sts_wdata | input | 8 | Data byte received with the status write |
| wp_n | input | 1 | Write-protect pin, active low |
| cyc_done | input | 1 | End of the self-timed programming cycle |
| status_q | output | 8 | Status byte for read-back |
| wr_permit | output | 1 | The current request may start |
| prot_en | output | 1 | Some address range is protected |
| prot_base | output | AW | Lowest protected address when prot_en is 1 |

## Verification
Most internal faults in this block show up at the ports one cycle after the event that exposes them. A stuck or early-cleared busy flag reads wrong in bit 0 on the cycle after the start strobe, and it also flips the permit flag of any later request. A block-protect value that is taken too early shows up in the range outputs during the cycle, before the done strobe. A wrong region decode shows up only when a write aims at the page on either side of the boundary, so those addresses are driven for each protect code. A latch that ignores the protect pin is seen one cycle after the pin drops.

// File: rtl/eg_pkg.sv
package eg_pkg;
  typedef logic [1:0] bp_t;
  localparam int STS_WIP = 0;
  localparam int STS_WEL = 1;
  localparam int STS_BP_LO = 2;
  localparam int STS_BP_HI = 3;
endpackage

// File: rtl/eg_region_dec.sv
module eg_region_dec #(
  parameter int AW = 9
) (
  input  eg_pkg::bp_t    bp,
  output logic           prot_en,
  output logic [AW-1:0]  prot_base
);
  localparam logic [AW-1:0] QTR_BASE  = {2'b11, {(AW-2){1'b0}}};
  localparam logic [AW-1:0] HALF_BASE = {1'b1, {(AW-1){1'b0}}};

  always_comb begin
    prot_en   = 1'b1;
    prot_base = '0;
    unique case (bp)
      2'b00: prot_en   = 1'b0;
      2'b01: prot_base = QTR_BASE;
      2'b10: prot_base = HALF_BASE;
      default: prot_base = '0;
    endcase
  end
endmodule

// File: rtl/eg_gate.sv
module eg_gate #(
  parameter int AW     = 9,
  parameter int PAGE_W = 4
) (
  input  logic          wel,
  input  logic          wip,
  input  logic          wp_n,
  input  logic          arr_req,
  input  logic          sts_req,
  input  logic [AW-1:0] addr,
  input  logic          prot_en,
  input  logic [AW-1:0] prot_base,
  output logic          arr_ok,
  output logic          sts_ok
);
  logic [AW-1:0] page_addr;
  logic          hit;

  generate
    if (PAGE_W == 0) begin : g_byte
      assign page_addr = addr;
    end else begin : g_page
      assign page_addr = {addr[AW-1:PAGE_W], {PAGE_W{1'b0}}};
    end
  endgenerate

  assign hit    = prot_en && (page_addr >= prot_base);
  assign arr_ok = arr_req && wel && !wip && wp_n && !hit;
  assign sts_ok = sts_req && wel && !wip && wp_n;
endmodule

// File: rtl/eg_status_core.sv
module eg_status_core (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wren,
  input  logic        wrdi,
  input  logic        wp_n,
  input  logic        cyc_done,
  input  logic        start_arr,
  input  logic        start_sts,
  input  eg_pkg::bp_t new_bp,
  output logic        wip,
  output logic        wel,
  output eg_pkg::bp_t bp
);
  logic        wip_d, wel_d, pend_d, pend_q, bp_en, finish;
  eg_pkg::bp_t pbp_d, pbp_q;

  assign finish = wip && cyc_done;
  assign bp_en  = finish && pend_q;

  always_comb begin
    wip_d  = wip;
    pend_d = pend_q;
    pbp_d  = pbp_q;
    if (finish) begin
      wip_d  = 1'b0;
      pend_d = 1'b0;
    end else if (start_arr || start_sts) begin
      wip_d  = 1'b1;
      pend_d = start_sts;
      pbp_d  = new_bp;
    end
    if (!wp_n || wrdi || finish) wel_d = 1'b0;
    else if (wren)               wel_d = 1'b1;
    else                         wel_d = wel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wip    <= 1'b0;
      wel    <= 1'b0;
      pend_q <= 1'b0;
      pbp_q  <= '0;
    end else begin
      wip    <= wip_d;
      wel    <= wel_d;
      pend_q <= pend_d;
      pbp_q  <= pbp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bp <= '0;
    else if (bp_en) bp <= pbp_q;
  end
endmodule

// File: rtl/eeprom_guard.sv
module eeprom_guard #(
  parameter int AW     = 9,
  parameter int PAGE_W = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wren_evt,
  input  logic          wrdi_evt,
  input  logic          arr_wr_req,
  input  logic          sts_wr_req,
  input  logic [AW-1:0] tgt_addr,
  input  logic [7:0]    sts_wdata,
  input  logic          wp_n,
  input  logic          cyc_done,
  output logic [7:0]    status_q,
  output logic          wr_permit,
  output logic          prot_en,
  output logic [AW-1:0] prot_base
);
  logic [1:0]  rst_sync;
  logic        core_rst_n, wip, wel, arr_ok, sts_ok;
  eg_pkg::bp_t bp;
  logic        unused_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign core_rst_n   = rst_sync[1];
  assign unused_wdata = ^{sts_wdata[7:4], sts_wdata[1:0]};

  eg_region_dec #(.AW(AW)) u_region (
    .bp(bp), .prot_en(prot_en), .prot_base(prot_base)
  );

  eg_gate #(.AW(AW), .PAGE_W(PAGE_W)) u_gate (
    .wel(wel), .wip(wip), .wp_n(wp_n), .arr_req(arr_wr_req),
    .sts_req(sts_wr_req), .addr(tgt_addr), .prot_en(prot_en),
    .prot_base(prot_base), .arr_ok(arr_ok), .sts_ok(sts_ok)
  );

  eg_status_core u_core (
    .clk(clk), .rst_n(core_rst_n), .wren(wren_evt), .wrdi(wrdi_evt),
    .wp_n(wp_n), .cyc_done(cyc_done), .start_arr(arr_ok),
    .start_sts(sts_ok), .new_bp(sts_wdata[eg_pkg::STS_BP_HI:eg_pkg::STS_BP_LO]),
    .wip(wip), .wel(wel), .bp(bp)
  );

  assign wr_permit = arr_ok || sts_ok;

  always_comb begin
    status_q = 8'h00;
    status_q[eg_pkg::STS_WIP] = wip;
    status_q[eg_pkg::STS_WEL] = wel;
    status_q[eg_pkg::STS_BP_HI:eg_pkg::STS_BP_LO] = bp;
  end
endmodule

// File: rtl/eg_checker.sv
module eg_checker #(
  parameter int AW = 9
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wp_n,
  input logic          cyc_done,
  input logic          arr_wr_req,
  input logic [AW-1:0] tgt_addr,
  input logic          wr_permit,
  input logic [7:0]    status_q,
  input logic          prot_en,
  input logic [AW-1:0] prot_base
);
  p_busy_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && !cyc_done) |=> status_q[0]);

  p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (status_q[0] && cyc_done) |=> (!status_q[0] && !status_q[1]));

  p_start_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |=> status_q[0]);

  p_pin_clears_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !wp_n |=> !status_q[1]);

  p_permit_gated_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_permit |-> (wp_n && status_q[1] && !status_q[0]));

  p_outside_region_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (arr_wr_req && wr_permit) |-> !(prot_en && tgt_addr >= prot_base));

  p_bp_only_at_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_q[0] && cyc_done) |=> $stable(status_q[3:2]));
endmodule

bind eeprom_guard eg_checker #(.AW(AW)) u_eg_checker (
  .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .cyc_done(cyc_done),
  .arr_wr_req(arr_wr_req), .tgt_addr(tgt_addr), .wr_permit(wr_permit),
  .status_q(status_q), .prot_en(prot_en), .prot_base(prot_base)
);

// File: tb/eeprom_guard_bench.sv
`timescale 1ns/1ps
module eeprom_guard_bench;
  localparam int AW = 9;

  logic clk = 1'b0;
  logic rst_n;
  logic wren_evt, wrdi_evt, arr_wr_req, sts_wr_req, wp_n, cyc_done;
  logic [AW-1:0] tgt_addr;
  logic [7:0] sts_wdata, status_q;
  logic wr_permit, prot_en;
  logic [AW-1:0] prot_base;

  always #5 clk = ~clk;

  eeprom_guard u_eeprom_guard (
    .clk(clk), .rst_n(rst_n), .wren_evt(wren_evt), .wrdi_evt(wrdi_evt),
    .arr_wr_req(arr_wr_req), .sts_wr_req(sts_wr_req), .tgt_addr(tgt_addr),
    .sts_wdata(sts_wdata), .wp_n(wp_n), .cyc_done(cyc_done),
    .status_q(status_q), .wr_permit(wr_permit), .prot_en(prot_en),
    .prot_base(prot_base)
  );

  typedef struct {
    string         tag;
    logic          permit;
    logic [7:0]    sts;
    logic          pen;
    logic [AW-1:0] pbase;
  } item_t;

  item_t q[$];
  int checks = 0;
  int fails  = 0;

  // reference state, derived from the requirements
  logic m_wip = 1'b0, m_wel = 1'b0, m_pend = 1'b0;
  logic [1:0] m_bp = 2'b00, m_pbp = 2'b00;

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic cyc(string tag, logic en, logic dis, logic arr, logic sts,
                     logic [AW-1:0] addr, logic [7:0] wd, logic wp, logic done);
    item_t it;
    logic hit, perm, fin;
    @(negedge clk);
    wren_evt = en; wrdi_evt = dis; arr_wr_req = arr; sts_wr_req = sts;
    tgt_addr = addr; sts_wdata = wd; wp_n = wp; cyc_done = done;
    case (m_bp)
      2'b00: hit = 1'b0;
      2'b01: hit = (addr >= 9'h180);
      2'b10: hit = (addr >= 9'h100);
      default: hit = 1'b1;
    endcase
    it.pen   = (m_bp != 2'b00);
    it.pbase = (m_bp == 2'b01) ? 9'h180 : (m_bp == 2'b10) ? 9'h100 : 9'h000;
    perm = m_wel && !m_wip && wp && ((arr && !hit) || sts);
    fin  = m_wip && done;
    if (fin) begin
      m_wip = 1'b0;
      if (m_pend) m_bp = m_pbp;
      m_pend = 1'b0;
    end else if (perm) begin
      m_wip = 1'b1; m_pend = sts; m_pbp = wd[3:2];
    end
    if (!wp || dis || fin) m_wel = 1'b0;
    else if (en)           m_wel = 1'b1;
    it.tag    = tag;
    it.permit = perm;
    it.sts    = {4'b0000, m_bp, m_wel, m_wip};
    q.push_back(it);
  endtask

  task automatic idle(string tag, int n);
    for (int i = 0; i < n; i++) cyc(tag, 0, 0, 0, 0, '0, '0, 1, 0);
  endtask

  // monitor: permit and range sampled late in the cycle, status after the edge
  initial begin
    logic s_perm, s_pen;
    logic [AW-1:0] s_base;
    item_t it;
    forever begin
      @(negedge clk);
      #3;
      s_perm = wr_permit; s_pen = prot_en; s_base = prot_base;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        it = q.pop_front();
        chk(it.tag, "permit", s_perm, it.permit);
        chk(it.tag, "status", status_q, it.sts);
        chk(it.tag, "prot_en", s_pen, it.pen);
        if (it.pen) chk(it.tag, "prot_base", s_base, it.pbase);
      end
    end
  end

  initial begin
    #1_000_000;
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    wren_evt = 0; wrdi_evt = 0; arr_wr_req = 0; sts_wr_req = 0;
    tgt_addr = '0; sts_wdata = '0; wp_n = 1; cyc_done = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    idle("R1_reset", 1);
    // R4 / R10: write without latch refused
    cyc("R4_no_latch", 0, 0, 1, 0, 9'h010, 0, 1, 0);
    cyc("R10_refused", 0, 0, 0, 0, 0, 0, 1, 0);
    // R2
    cyc("R2_set", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R2_clear", 0, 1, 0, 0, 0, 0, 1, 0);
    // R3
    cyc("R3_blocked", 1, 0, 0, 0, 0, 0, 0, 0);
    cyc("R3_set", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R3_pin_low", 0, 0, 0, 0, 0, 0, 0, 0);
    // R4 / R6 array write cycle
    cyc("R2_set2", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R4_ok", 0, 0, 1, 0, 9'h1F0, 0, 1, 0);
    idle("R6_busy", 3);
    cyc("R4_busy_refused", 0, 0, 1, 0, 9'h000, 0, 1, 0);
    cyc("R5_busy_refused", 0, 0, 0, 1, 0, 8'h0C, 1, 0);
    cyc("R6_done", 0, 0, 0, 0, 0, 0, 1, 1);
    // R11
    cyc("R11_stray_done", 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R11_after", 1, 0, 0, 0, 0, 0, 1, 1);
    // R5 / R8 status write to 11
    cyc("R5_ok", 0, 0, 0, 1, 0, 8'hFF, 1, 0);
    idle("R8_old_bp", 2);
    cyc("R8_done", 0, 0, 0, 0, 0, 0, 1, 1);
    idle("R7_whole", 1);
    cyc("R2_set3", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R7_whole_refused", 0, 0, 1, 0, 9'h000, 0, 1, 0);
    // R7 quarter
    cyc("R5_quarter", 0, 0, 0, 1, 0, 8'h04, 1, 0);
    cyc("R8_q_done", 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R2_set4", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R7_q_below", 0, 0, 1, 0, 9'h17F, 0, 1, 0);
    cyc("R7_q_done", 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R2_set5", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R7_q_at", 0, 0, 1, 0, 9'h180, 0, 1, 0);
    // R7 half
    cyc("R5_half", 0, 0, 0, 1, 0, 8'h08, 1, 0);
    cyc("R8_h_done", 0, 0, 0, 0, 0, 0, 1, 1);
    cyc("R2_set6", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R7_h_at", 0, 0, 1, 0, 9'h100, 0, 1, 0);
    cyc("R7_h_below", 0, 0, 1, 0, 9'h0FF, 0, 1, 0);
    cyc("R7_h_done", 0, 0, 0, 0, 0, 0, 1, 1);
    // R9 pin low during cycle
    cyc("R2_set7", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R9_start", 0, 0, 1, 0, 9'h010, 0, 1, 0);
    cyc("R9_pin_low", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R9_still_busy", 0, 0, 0, 0, 0, 0, 0, 0);
    cyc("R9_done", 0, 0, 0, 0, 0, 0, 0, 1);
    // R5 pin low refuses status write
    cyc("R5_pin_set", 1, 0, 0, 0, 0, 0, 1, 0);
    cyc("R5_pin_low", 0, 0, 0, 1, 0, 8'h00, 0, 0);
    cyc("R5_no_latch", 0, 0, 0, 1, 0, 8'h00, 1, 0);
    idle("R1_final", 2);
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule